// File: doc/BRIEF.md
# Dual-Page Display Write Decoder

This block sits behind a serial command receiver in an on-screen character display controller. Each incoming write carries a 9-bit address and a 16-bit word. The block routes the write to one of four places: the page 0 character memory, the page 1 character memory, the page 0 control registers or the page 1 control registers.

Both pages share one address space. The page is chosen by the most significant bit of the data word, not by the address. The character memories are outside the block. For them the block produces a write strobe, an address and a cleaned-up 15-bit payload.

The control registers are held inside the block, one copy per page, and are presented as flat vectors to the display timing logic. Some register fields are common to both pages. Those fields live only in the page 0 copy, and a page 1 write never reaches them.

Top module: `dpw_top`

## Requirements
- R1: An address below 0x120 (288) selects character memory. Addresses 0x120 to 0x128 select control register index (address − 0x120), 0 to 8.
- R2: Bit 15 of the data word selects the page. A value of 0 targets page 0 and a value of 1 targets page 1. The same address reaches either page.
- R3: A page 0 memory write passes data bits 14:0 to `ram_data` unchanged. Within those bits, 7:0 are the glyph code, 10:8 are the foreground R,G,B, bit 11 is blink and 14:12 are the background R,G,B.
- R4: A page 1 memory write forces `ram_data` bit 7 to 0 and leaves every other bit of 14:0 as written.
- R5: A page 1 register write stores data[14:0] AND the page-local mask of that index into the page 1 copy. All other bits of the page 1 copy become 0, and the page 0 copy stays unchanged. The masks by index are:
  - 0 and 1: 0x0000
  - 2 and 3: 0x3FFF
  - 4: 0x1FFF
  - 5: 0x03FF
  - 6: 0x3FFF
  - 7: 0x0FFF
  - 8: 0x1FFF
- R6: A page 0 register write stores all of data[14:0] into the page 0 copy, and the page 1 copy stays unchanged. `reg_data` carries the stored value for either page.
- R7: Synchronous active-high reset clears every register in both copies to 0 and raises no strobe, even if a write is presented during reset.
- R8: A write to an address above 0x128 raises no strobe and changes no register.
- R9: Each accepted write raises exactly one of `ram0_we`, `ram1_we`, `reg0_we`, `reg1_we`. The strobe is high for one cycle, in the cycle after the write is presented, and register contents change in that same cycle. No strobe rises while `wr_valid` is low.
- R10: Register index i of a page appears at bits [15·i+14 : 15·i] of `ctrl_p0` or `ctrl_p1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A write is presented this cycle |
| wr_addr | input | 9 | Write address |
| wr_data | input | 16 | Write word; bit 15 selects the page |
| ram0_we | output | 1 | Page 0 character memory write strobe |
| ram1_we | output | 1 | Page 1 character memory write strobe |
| ram_addr | output | 9 | Character memory address |
| ram_data | output | 15 | Character memory payload |
| reg0_we | output | 1 | Page 0 register write strobe |
| reg1_we | output | 1 | Page 1 register write strobe |
| reg_idx | output | 4 | Register index written |
| reg_data | output | 15 | Value stored into the register |
| ctrl_p0 | output | 135 | Page 0 register copy, 9 × 15 bits |
| ctrl_p1 | output | 135 | Page 1 register copy, 9 × 15 bits |

## Verification
The same address is written with the page bit set and clear. This shows that page selection follows the data word and not the address.

Memory words are written with bit 7 set and with patterns that exercise every field. These separate a pass-through for page 0 from the bit-7 clearing for page 1.

Register writes of all-ones go to every index on both pages. Reading back both copies exposes a wrong mask, a leak of common fields into page 1, and any disturbance of the other copy.

The address boundaries 0x11F, 0x120, 0x128, 0x129 and 0x1FF, a reset applied while a write is presented, and idle cycles cover the map edges and the strobe rules.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 16;
    localparam int PAY_W  = DATA_W - 1;
    localparam int IDX_W  = 4;
    localparam int GLYPH_TOP = 7;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_RAM  = 2'd1,
        DST_REG  = 2'd2
    } dst_e;

    typedef struct packed {
        logic               valid;
        dst_e               dst;
        logic               page;
        logic [ADDR_W-1:0]  addr;
        logic [IDX_W-1:0]   idx;
        logic [PAY_W-1:0]   payload;
    } wr_cmd_t;

    // Bits that exist separately in the page 1 copy of each register;
    // the remaining bits are common and live only in page 0.
    function automatic logic [PAY_W-1:0] p1_keep_mask(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd2, 4'd3, 4'd6: p1_keep_mask = 15'h3FFF;
            4'd4, 4'd8:       p1_keep_mask = 15'h1FFF;
            4'd5:             p1_keep_mask = 15'h03FF;
            4'd7:             p1_keep_mask = 15'h0FFF;
            default:          p1_keep_mask = 15'h0000;
        endcase
    endfunction
endpackage

// File: rtl/dpw_classify.sv
module dpw_classify
    import dpw_pkg::*;
#(
    parameter int RAM_WORDS = 288,
    parameter int NREG      = 9
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cmd_t           cmd
);
    localparam logic [ADDR_W-1:0] RAM_END = ADDR_W'(RAM_WORDS);
    localparam logic [ADDR_W-1:0] REG_END = ADDR_W'(RAM_WORDS + NREG);

    logic [ADDR_W-1:0] reg_off;
    logic [PAY_W-1:0]  raw;

    always_comb begin
        raw         = wr_data[PAY_W-1:0];
        reg_off     = wr_addr - RAM_END;
        cmd.valid   = wr_valid;
        cmd.page    = wr_data[DATA_W-1];
        cmd.addr    = wr_addr;
        cmd.idx     = IDX_W'(reg_off);
        cmd.dst     = DST_NONE;
        cmd.payload = raw;
        if (wr_addr < RAM_END) begin
            cmd.dst = DST_RAM;
            if (cmd.page) cmd.payload[GLYPH_TOP] = 1'b0;
        end else if (wr_addr < REG_END) begin
            cmd.dst = DST_REG;
            if (cmd.page) cmd.payload = raw & p1_keep_mask(cmd.idx);
        end
    end
endmodule

// File: rtl/dpw_strobe_gen.sv
module dpw_strobe_gen
    import dpw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    output logic              ram0_we,
    output logic              ram1_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [PAY_W-1:0]  ram_data,
    output logic              reg0_we,
    output logic              reg1_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [PAY_W-1:0]  reg_data
);
    logic to_ram, to_reg;

    always_comb begin
        to_ram = cmd.valid && (cmd.dst == DST_RAM);
        to_reg = cmd.valid && (cmd.dst == DST_REG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ram0_we  <= 1'b0;
            ram1_we  <= 1'b0;
            reg0_we  <= 1'b0;
            reg1_we  <= 1'b0;
            ram_addr <= '0;
            ram_data <= '0;
            reg_idx  <= '0;
            reg_data <= '0;
        end else begin
            ram0_we <= to_ram && !cmd.page;
            ram1_we <= to_ram &&  cmd.page;
            reg0_we <= to_reg && !cmd.page;
            reg1_we <= to_reg &&  cmd.page;
            if (to_ram) begin
                ram_addr <= cmd.addr;
                ram_data <= cmd.payload;
            end
            if (to_reg) begin
                reg_idx  <= cmd.idx;
                reg_data <= cmd.payload;
            end
        end
    end
endmodule

// File: rtl/dpw_reg_bank.sv
module dpw_reg_bank
    import dpw_pkg::*;
#(
    parameter int NREG = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_cmd_t               cmd,
    output logic [NREG*PAY_W-1:0] ctrl_p0,
    output logic [NREG*PAY_W-1:0] ctrl_p1
);
    logic hit_reg;

    always_comb hit_reg = cmd.valid && (cmd.dst == DST_REG);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [PAY_W-1:0] p0_q, p1_q;
        logic sel;

        always_comb sel = hit_reg && (cmd.idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                p0_q <= '0;
                p1_q <= '0;
            end else if (sel) begin
                if (cmd.page) p1_q <= cmd.payload;
                else          p0_q <= cmd.payload;
            end
        end

        assign ctrl_p0[i*PAY_W +: PAY_W] = p0_q;
        assign ctrl_p1[i*PAY_W +: PAY_W] = p1_q;
    end
endmodule

// File: rtl/dpw_top.sv
module dpw_top
    import dpw_pkg::*;
#(
    parameter int RAM_WORDS = 288,
    parameter int NREG      = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_valid,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  ram0_we,
    output logic                  ram1_we,
    output logic [ADDR_W-1:0]     ram_addr,
    output logic [PAY_W-1:0]      ram_data,
    output logic                  reg0_we,
    output logic                  reg1_we,
    output logic [IDX_W-1:0]      reg_idx,
    output logic [PAY_W-1:0]      reg_data,
    output logic [NREG*PAY_W-1:0] ctrl_p0,
    output logic [NREG*PAY_W-1:0] ctrl_p1
);
    wr_cmd_t cmd;

    dpw_classify #(.RAM_WORDS(RAM_WORDS), .NREG(NREG)) u_classify (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmd      (cmd)
    );

    dpw_strobe_gen u_strobe (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ram0_we  (ram0_we),
        .ram1_we  (ram1_we),
        .ram_addr (ram_addr),
        .ram_data (ram_data),
        .reg0_we  (reg0_we),
        .reg1_we  (reg1_we),
        .reg_idx  (reg_idx),
        .reg_data (reg_data)
    );

    dpw_reg_bank #(.NREG(NREG)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .ctrl_p0 (ctrl_p0),
        .ctrl_p1 (ctrl_p1)
    );
endmodule

// File: rtl/dpw_chk.sv
module dpw_chk
    import dpw_pkg::*;
#(
    parameter int RAM_WORDS = 288,
    parameter int NREG      = 9
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_valid,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic                  ram0_we,
    input logic                  ram1_we,
    input logic [PAY_W-1:0]      ram_data,
    input logic                  reg0_we,
    input logic                  reg1_we,
    input logic [IDX_W-1:0]      reg_idx,
    input logic [PAY_W-1:0]      reg_data,
    input logic [NREG*PAY_W-1:0] ctrl_p0,
    input logic [NREG*PAY_W-1:0] ctrl_p1
);
    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram0_we, ram1_we, reg0_we, reg1_we}));

    // R8
    out_of_map_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr >= ADDR_W'(RAM_WORDS + NREG))
        |=> !(ram0_we || ram1_we || reg0_we || reg1_we));

    // R2
    ram_page0_route_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr < ADDR_W'(RAM_WORDS) && !wr_data[DATA_W-1]) |=> ram0_we);

    // R4
    p1_glyph_chk: assert property (@(posedge clk) disable iff (rst)
        ram1_we |-> !ram_data[GLYPH_TOP]);

    // R5
    p1_common_clear_chk: assert property (@(posedge clk) disable iff (rst)
        reg1_we |-> ((reg_data & ~p1_keep_mask(reg_idx)) == '0));

    // R5
    p0_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        reg1_we |-> $stable(ctrl_p0));

    // R6
    p1_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        reg0_we |-> $stable(ctrl_p1));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctrl_p0 == '0 && ctrl_p1 == '0 && !ram0_we && !ram1_we));
endmodule

bind dpw_top dpw_chk #(.RAM_WORDS(RAM_WORDS), .NREG(NREG)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ram0_we  (ram0_we),
    .ram1_we  (ram1_we),
    .ram_data (ram_data),
    .reg0_we  (reg0_we),
    .reg1_we  (reg1_we),
    .reg_idx  (reg_idx),
    .reg_data (reg_data),
    .ctrl_p0  (ctrl_p0),
    .ctrl_p1  (ctrl_p1)
);

// File: tb/dpw_top_tb.sv
module dpw_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 9;
    localparam int PW = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_valid = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic ram0_we, ram1_we, reg0_we, reg1_we;
    logic [8:0]  ram_addr;
    logic [14:0] ram_data, reg_data;
    logic [3:0]  reg_idx;
    logic [NR*PW-1:0] ctrl_p0, ctrl_p1;

    int checks = 0;
    int failures = 0;
    logic [14:0] m0 [NR];
    logic [14:0] m1 [NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpw_top u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .ram0_we(ram0_we), .ram1_we(ram1_we), .ram_addr(ram_addr), .ram_data(ram_data),
        .reg0_we(reg0_we), .reg1_we(reg1_we), .reg_idx(reg_idx), .reg_data(reg_data),
        .ctrl_p0(ctrl_p0), .ctrl_p1(ctrl_p1)
    );

    function automatic logic [14:0] keep1(input int i);
        case (i)
            2, 3, 6: return 15'h3FFF;
            4, 8:    return 15'h1FFF;
            5:       return 15'h03FF;
            7:       return 15'h0FFF;
            default: return 15'h0000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {ram0_we, ram1_we, reg0_we, reg1_we};
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < NR; i++) begin
            chk({req, " p0"}, 32'(ctrl_p0[i*PW +: PW]), 32'(m0[i]));
            chk({req, " p1"}, 32'(ctrl_p1[i*PW +: PW]), 32'(m1[i]));
        end
    endtask

    // Present one write, return one negedge later with outputs settled.
    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < NR; i++) begin m0[i] = '0; m1[i] = '0; end
        chk("R7 strobes after reset", 32'(strobes()), 0);
        check_regs("R7 reset value");
    endtask

    task automatic t_ram_p0();
        wr(9'h000, 16'h7FFF);
        chk("R2 R9 ram0 strobe", 32'(strobes()), 32'b1000);
        chk("R3 data", 32'(ram_data), 32'h7FFF);
        chk("R1 addr", 32'(ram_addr), 32'h000);
        wr(9'h11F, 16'h2A95);
        chk("R1 last ram addr strobe", 32'(strobes()), 32'b1000);
        chk("R3 field pattern", 32'(ram_data), 32'h2A95);
        chk("R1 addr 11F", 32'(ram_addr), 32'h11F);
        @(negedge clk);
        chk("R9 single cycle", 32'(strobes()), 0);
    endtask

    task automatic t_ram_p1();
        wr(9'h11F, 16'hFFFF);
        chk("R2 ram1 strobe", 32'(strobes()), 32'b0100);
        chk("R4 bit7 cleared", 32'(ram_data), 32'h7F7F);
        wr(9'h055, 16'h8A5A);
        chk("R4 other bits kept", 32'(ram_data), 32'h0A5A);
        chk("R1 addr 055", 32'(ram_addr), 32'h055);
    endtask

    task automatic t_reg_p0();
        for (int i = 0; i < NR; i++) begin
            wr(9'(9'h120 + i), 16'(16'h7FFF - i));
            m0[i] = 15'(15'h7FFF - i);
            chk("R6 reg0 strobe", 32'(strobes()), 32'b0010);
            chk("R1 index", 32'(reg_idx), 32'(i));
            chk("R6 reg_data", 32'(reg_data), 32'(m0[i]));
        end
        check_regs("R6 R10 page0 bank");
    endtask

    task automatic t_reg_p1();
        for (int i = 0; i < NR; i++) begin
            wr(9'(9'h120 + i), 16'hFFFF);
            m1[i] = keep1(i);
            chk("R5 reg1 strobe", 32'(strobes()), 32'b0001);
            chk("R5 masked data", 32'(reg_data), 32'(m1[i]));
        end
        check_regs("R5 R10 page1 bank");
        // Rewrite with a sparse pattern: bits outside the mask must drop to 0.
        wr(9'h124, 16'hC001);
        m1[4] = 15'h0001;
        check_regs("R5 common bits not stored");
        // Page 0 write again must leave page 1 alone.
        wr(9'h124, 16'h0123);
        m0[4] = 15'h0123;
        check_regs("R6 page1 untouched");
    endtask

    task automatic t_out_of_map();
        wr(9'h129, 16'h1234);
        chk("R8 0x129 no strobe", 32'(strobes()), 0);
        wr(9'h1FF, 16'hFFFF);
        chk("R8 0x1FF no strobe", 32'(strobes()), 0);
        check_regs("R8 regs unchanged");
        wr_addr = 9'h120; wr_data = 16'h0FFF; wr_valid = 1'b0;
        @(negedge clk);
        chk("R9 idle no strobe", 32'(strobes()), 0);
        check_regs("R9 idle regs unchanged");
    endtask

    task automatic t_reset_mid();
        rst = 1'b1;
        wr(9'h010, 16'h1111);
        chk("R7 no strobe in reset", 32'(strobes()), 0);
        rst = 1'b0;
        for (int i = 0; i < NR; i++) begin m0[i] = '0; m1[i] = '0; end
        check_regs("R7 cleared");
        wr(9'h010, 16'h1111);
        chk("R7 resumes", 32'(strobes()), 32'b1000);
    endtask

    initial begin
        fork
            begin
                repeat (2) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                t_reset();
                t_ram_p0();
                t_ram_p1();
                t_reg_p0();
                t_reg_p1();
                t_out_of_map();
                t_reset_mid();
            end
            begin
                repeat (20000) @(negedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule